// File: doc/BRIEF.md
# 100BASE-X PCS Receive Decoder

This block sits after code-group alignment and descrambling in a 100 Mb/s receive path. It takes one aligned 5-bit code group per input strobe and drives the nibble-wide media-independent receive side: a data-valid level, a receive-error flag, a 4-bit nibble and a one-cycle strobe per nibble period. When it finds a start delimiter, it hides the two delimiter symbols and sends two preamble nibbles in their place. Data code groups inside the frame are translated back to nibbles. A frame ends on the end delimiter pair, on loss of carrier, or on a final partial group.

Output lags the input by one code group. The nibble for a group is held back until the next group shows whether the frame goes on. Because of this, the end delimiter, a trailing partial group and a carrier drop can each be handled at a clean boundary. The upstream aligner marks a final partial group with a separate tail strobe. That strobe carries how many leftover data bits remain (0 to 7) and the first four of them. One to four leftover bits become a single nibble padded with 1s. Five to seven leftover bits yield only their first nibble.

Top module: `pcs_rx_dec`

## Requirements
- R1: Inside a frame, each data code group is turned into its nibble using the 16-entry 4B/5B map (nibble 0 = 11110, 1 = 01001, 2 = 10100, 3 = 10101, 4 = 01010, 5 = 01011, 6 = 01110, 7 = 01111, 8 = 10010, 9 = 10011, A = 10110, B = 10111, C = 11010, D = 11011, E = 11100, F = 11101, cg_i[4] first). Nibbles leave in input order, and each one is presented on the strobe of the following group.
- R2: /J/ (11000) followed directly by /K/ (10001) raises rx_dv_o and yields two nibbles of value 0x5, one per delimiter symbol, before any data nibble.
- R3: /J/ followed by any group other than /K/ is a false carrier. No nibble is strobed, rx_dv_o stays low, and the block waits for a new /J/.
- R4: /T/ (01101) inside a frame releases the last held data nibble. It emits nothing for itself or for the following /R/ (00111) group, and rx_dv_o is low from the cycle after that last nibble.
- R5: A group inside a frame that is neither data nor /T/ produces a nibble with rx_er_o high. rx_er_o is high only on strobes with rx_dv_o high. The nibble value under rx_er_o is not specified.
- R6: A tail strobe in a frame with a count of 1 to 4 adds one final nibble. Its bit i is tail_bits_i[i] for i below the count and 1 otherwise.
- R7: A tail strobe with a count of 5 to 7 adds exactly one final nibble, equal to tail_bits_i. A count of 0 adds none. In every case rx_dv_o falls once the tail is handled.
- R8: A low carrier_i ends any frame. In the next cycle rx_dv_o and rx_stb_o are low, and the held nibble is discarded.
- R9: Outside a frame, rx_stb_o and rx_dv_o stay low whatever groups arrive, and rx_stb_o never pulses without rx_dv_o.
- R10: After reset, all outputs are low and the block is waiting for /J/.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Carrier present from the link detector |
| cg_vld_i | input | 1 | Code-group strobe |
| cg_i | input | 5 | Aligned, descrambled code group |
| tail_vld_i | input | 1 | Final partial group strobe (takes precedence over cg_vld_i) |
| tail_cnt_i | input | 3 | Number of leftover data bits, 0 to 7 |
| tail_bits_i | input | 4 | First leftover bits, bit 0 received first |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error for the strobed nibble |
| rx_stb_o | output | 1 | One-cycle pulse per nibble period |
| rxd_o | output | 4 | Receive nibble |

## Verification
The assertions assume that a tail strobe is never followed in the next cycle by another strobe, and that a tail strobe and a group strobe never arrive together. The bench always leaves idle cycles after a tail and drives the two strobes from separate tasks, one at a time. Carrier stays high through random frames and drops only in the directed loss-of-carrier case. Random gaps between strobes check that rx_dv_o holds as a level across idle cycles.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int CG_W   = 5;
  localparam int NIB_W  = 4;
  localparam int TCNT_W = 3;

  localparam logic [CG_W-1:0] CG_J = 5'b11000;
  localparam logic [CG_W-1:0] CG_K = 5'b10001;
  localparam logic [CG_W-1:0] CG_T = 5'b01101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT_J,
    ST_FRAME,
    ST_END_T,
    ST_TAIL
  } rx_state_e;
endpackage

// File: rtl/pcs_rx_cg_dec.sv
module pcs_rx_cg_dec
  import pcs_rx_pkg::*;
#(
  parameter int C_W = CG_W,
  parameter int N_W = NIB_W
) (
  input  logic [C_W-1:0] cg_i,
  output logic [N_W-1:0] data_o,
  output logic           is_data_o,
  output logic           is_j_o,
  output logic           is_k_o,
  output logic           is_t_o
);
  always_comb begin
    is_data_o = 1'b1;
    data_o    = '0;
    unique case (cg_i)
      5'b11110: data_o = N_W'(4'h0);
      5'b01001: data_o = N_W'(4'h1);
      5'b10100: data_o = N_W'(4'h2);
      5'b10101: data_o = N_W'(4'h3);
      5'b01010: data_o = N_W'(4'h4);
      5'b01011: data_o = N_W'(4'h5);
      5'b01110: data_o = N_W'(4'h6);
      5'b01111: data_o = N_W'(4'h7);
      5'b10010: data_o = N_W'(4'h8);
      5'b10011: data_o = N_W'(4'h9);
      5'b10110: data_o = N_W'(4'ha);
      5'b10111: data_o = N_W'(4'hb);
      5'b11010: data_o = N_W'(4'hc);
      5'b11011: data_o = N_W'(4'hd);
      5'b11100: data_o = N_W'(4'he);
      5'b11101: data_o = N_W'(4'hf);
      default:  is_data_o = 1'b0;
    endcase
  end

  assign is_j_o = (cg_i == CG_J);
  assign is_k_o = (cg_i == CG_K);
  assign is_t_o = (cg_i == CG_T);
endmodule

// File: rtl/pcs_rx_dribble.sv
module pcs_rx_dribble
  import pcs_rx_pkg::*;
#(
  parameter int N_W = NIB_W,
  parameter int C_W = TCNT_W
) (
  input  logic [C_W-1:0] cnt_i,
  input  logic [N_W-1:0] bits_i,
  output logic [N_W-1:0] nib_o,
  output logic           has_nib_o
);
  // Positions past the leftover count are filled with 1s; at or above N_W bits only the first nibble survives
  for (genvar i = 0; i < N_W; i++) begin : g_pad
    assign nib_o[i] = (int'(cnt_i) > i) ? bits_i[i] : 1'b1;
  end

  assign has_nib_o = (cnt_i != '0);
endmodule

// File: rtl/pcs_rx_ctrl.sv
module pcs_rx_ctrl
  import pcs_rx_pkg::*;
#(
  parameter int               N_W     = NIB_W,
  parameter logic [N_W-1:0]   PRE_NIB = N_W'(4'h5)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           carrier_i,
  input  logic           cg_vld_i,
  input  logic [N_W-1:0] data_i,
  input  logic           is_data_i,
  input  logic           is_j_i,
  input  logic           is_k_i,
  input  logic           is_t_i,
  input  logic           tail_vld_i,
  input  logic [N_W-1:0] tail_nib_i,
  input  logic           tail_has_i,
  input  logic           tail_cnt_zero_i,
  output logic           rx_dv_o,
  output logic           rx_er_o,
  output logic           rx_stb_o,
  output logic [N_W-1:0] rxd_o
);
  rx_state_e      state_q, state_d;
  logic [N_W-1:0] hold_nib_q, hold_nib_d;
  logic           hold_er_q, hold_er_d;
  logic [N_W-1:0] tail_nib_q;
  logic           tail_has_q;
  logic           tail_ld;
  logic           emit;
  logic [N_W-1:0] emit_nib;
  logic           emit_er;

  always_comb begin
    state_d    = state_q;
    hold_nib_d = hold_nib_q;
    hold_er_d  = hold_er_q;
    tail_ld    = 1'b0;
    emit       = 1'b0;
    emit_nib   = hold_nib_q;
    emit_er    = hold_er_q;
    if (!carrier_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cg_vld_i && is_j_i) state_d = ST_GOT_J;
        ST_GOT_J: begin
          if (cg_vld_i) begin
            if (is_k_i) begin
              // first preamble nibble now, second held for the next group slot
              emit       = 1'b1;
              emit_nib   = PRE_NIB;
              emit_er    = 1'b0;
              hold_nib_d = PRE_NIB;
              hold_er_d  = 1'b0;
              state_d    = ST_FRAME;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_FRAME: begin
          if (tail_vld_i) begin
            emit    = 1'b1;
            tail_ld = 1'b1;
            state_d = ST_TAIL;
          end else if (cg_vld_i) begin
            emit = 1'b1;
            if (is_t_i) begin
              state_d = ST_END_T;
            end else begin
              hold_nib_d = is_data_i ? data_i : '0;
              hold_er_d  = !is_data_i;
            end
          end
        end
        ST_END_T: if (cg_vld_i) state_d = ST_IDLE;
        ST_TAIL: begin
          emit     = tail_has_q;
          emit_nib = tail_nib_q;
          emit_er  = 1'b0;
          state_d  = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      hold_nib_q <= '0;
      hold_er_q  <= 1'b0;
      tail_nib_q <= '0;
      tail_has_q <= 1'b0;
      rx_dv_o    <= 1'b0;
      rx_er_o    <= 1'b0;
      rx_stb_o   <= 1'b0;
      rxd_o      <= '0;
    end else begin
      state_q    <= state_d;
      hold_nib_q <= hold_nib_d;
      hold_er_q  <= hold_er_d;
      if (tail_ld) begin
        tail_nib_q <= tail_nib_i;
        tail_has_q <= tail_has_i;
      end
      rx_stb_o <= emit;
      rx_er_o  <= emit && emit_er;
      rx_dv_o  <= emit || (state_d == ST_FRAME) || (state_d == ST_TAIL);
      if (emit) rxd_o <= emit_nib;
    end
  end

  p_stb_needs_dv_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_o |-> rx_dv_o);

  p_er_with_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> (rx_stb_o && rx_dv_o));

  p_preamble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GOT_J && carrier_i && cg_vld_i && is_k_i)
    |=> (rx_stb_o && rx_dv_o && !rx_er_o && rxd_o == PRE_NIB));

  p_false_carrier_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GOT_J && cg_vld_i && !is_k_i) |=> !rx_dv_o);

  p_term_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && carrier_i && !tail_vld_i && cg_vld_i && is_t_i)
    |=> rx_stb_o ##1 !rx_dv_o);

  p_tail_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) |=> ##1 !rx_dv_o);

  p_tail_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME && tail_vld_i && tail_cnt_zero_i) |=> ##1 (!rx_dv_o && !rx_stb_o));

  p_carrier_loss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_i |=> (!rx_dv_o && !rx_stb_o));
endmodule

// File: rtl/pcs_rx_dec.sv
module pcs_rx_dec
  import pcs_rx_pkg::*;
#(
  parameter int               C_W     = CG_W,
  parameter int               N_W     = NIB_W,
  parameter int               T_W     = TCNT_W,
  parameter logic [N_W-1:0]   PRE_NIB = N_W'(4'h5)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           carrier_i,
  input  logic           cg_vld_i,
  input  logic [C_W-1:0] cg_i,
  input  logic           tail_vld_i,
  input  logic [T_W-1:0] tail_cnt_i,
  input  logic [N_W-1:0] tail_bits_i,
  output logic           rx_dv_o,
  output logic           rx_er_o,
  output logic           rx_stb_o,
  output logic [N_W-1:0] rxd_o
);
  logic [N_W-1:0] dec_data;
  logic           dec_is_data, dec_is_j, dec_is_k, dec_is_t;
  logic [N_W-1:0] tail_nib;
  logic           tail_has;

  pcs_rx_cg_dec #(.C_W(C_W), .N_W(N_W)) u_cg_dec (
    .cg_i      (cg_i),
    .data_o    (dec_data),
    .is_data_o (dec_is_data),
    .is_j_o    (dec_is_j),
    .is_k_o    (dec_is_k),
    .is_t_o    (dec_is_t)
  );

  pcs_rx_dribble #(.N_W(N_W), .C_W(T_W)) u_dribble (
    .cnt_i     (tail_cnt_i),
    .bits_i    (tail_bits_i),
    .nib_o     (tail_nib),
    .has_nib_o (tail_has)
  );

  pcs_rx_ctrl #(.N_W(N_W), .PRE_NIB(PRE_NIB)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .carrier_i       (carrier_i),
    .cg_vld_i        (cg_vld_i),
    .data_i          (dec_data),
    .is_data_i       (dec_is_data),
    .is_j_i          (dec_is_j),
    .is_k_i          (dec_is_k),
    .is_t_i          (dec_is_t),
    .tail_vld_i      (tail_vld_i),
    .tail_nib_i      (tail_nib),
    .tail_has_i      (tail_has),
    .tail_cnt_zero_i (tail_cnt_i == '0),
    .rx_dv_o         (rx_dv_o),
    .rx_er_o         (rx_er_o),
    .rx_stb_o        (rx_stb_o),
    .rxd_o           (rxd_o)
  );
endmodule

// File: tb/pcs_rx_dec_tb.sv
`timescale 1ns/1ps
module pcs_rx_dec_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier = 1'b0;
  logic       cg_vld = 1'b0;
  logic [4:0] cg = 5'b11111;
  logic       tail_vld = 1'b0;
  logic [2:0] tail_cnt = '0;
  logic [3:0] tail_bits = '0;
  logic       rx_dv, rx_er, rx_stb;
  logic [3:0] rxd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] cap_nib [0:63];
  logic       cap_er  [0:63];
  int         cap_n = 0;
  logic [3:0] exp_nib [0:63];
  logic       exp_er  [0:63];
  int         exp_n = 0;

  always #2 clk = ~clk;

  pcs_rx_dec u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .carrier_i   (carrier),
    .cg_vld_i    (cg_vld),
    .cg_i        (cg),
    .tail_vld_i  (tail_vld),
    .tail_cnt_i  (tail_cnt),
    .tail_bits_i (tail_bits),
    .rx_dv_o     (rx_dv),
    .rx_er_o     (rx_er),
    .rx_stb_o    (rx_stb),
    .rxd_o       (rxd)
  );

  always @(negedge clk) begin
    if (rst_n && rx_stb && cap_n < 64) begin
      cap_nib[cap_n] = rxd;
      cap_er[cap_n]  = rx_er;
      cap_n++;
    end
  end

  function automatic logic [4:0] enc(input logic [3:0] d);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[d];
  endfunction

  function automatic logic [3:0] exp_tail(input int cnt, input logic [3:0] b);
    logic [3:0] r = 4'hf;
    for (int i = 0; i < 4; i++) if (i < cnt) r[i] = b[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [4:0] c);
    cg_vld = 1'b1;
    cg = c;
    @(negedge clk);
    cg_vld = 1'b0;
    cg = 5'b11111;
  endtask

  task automatic send_tail(input int cnt, input logic [3:0] b);
    tail_vld = 1'b1;
    tail_cnt = 3'(cnt);
    tail_bits = b;
    @(negedge clk);
    tail_vld = 1'b0;
  endtask

  task automatic push_exp(input logic [3:0] n, input logic e);
    exp_nib[exp_n] = n;
    exp_er[exp_n] = e;
    exp_n++;
  endtask

  task automatic compare(input string tag);
    chk(cap_n == exp_n, {tag, " nibble count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_er[i] == exp_er[i], {tag, " rx_er"}, cap_er[i], exp_er[i]);
      if (!exp_er[i])
        chk(cap_nib[i] == exp_nib[i], (i < 2) ? "R2 preamble" : {tag, " nibble"}, cap_nib[i], exp_nib[i]);
    end
  endtask

  // end_mode 0: /T/ /R/ (R4); 1: tail strobe (R6, R7)
  task automatic run_frame(input int nd, input int err_pos, input int end_mode,
                           input int tcnt, input logic [3:0] tbits, input bit seq);
    cap_n = 0;
    exp_n = 0;
    send(5'b11111);
    send(5'b11000);
    send(5'b10001);
    push_exp(4'h5, 1'b0);
    push_exp(4'h5, 1'b0);
    for (int i = 0; i < nd; i++) begin
      logic [3:0] d = seq ? 4'(i) : 4'($urandom_range(0, 15));
      idle($urandom_range(0, 2));
      if (i == err_pos) begin
        send(($urandom_range(0, 1) == 0) ? 5'b00000 : 5'b11111);
        push_exp(4'h0, 1'b1);
      end else begin
        send(enc(d));
        push_exp(d, 1'b0);
      end
      chk(rx_dv == 1'b1, "R1 dv held in frame", rx_dv, 1);
    end
    idle($urandom_range(0, 2));
    if (end_mode == 0) begin
      send(5'b01101);
      send(5'b00111);
    end else begin
      send_tail(tcnt, tbits);
      if (tcnt != 0) push_exp(exp_tail(tcnt, tbits), 1'b0);
    end
    idle(3);
    chk(rx_dv == 1'b0, end_mode == 0 ? "R4 dv low after end" : "R7 dv low after tail", rx_dv, 0);
    compare(end_mode == 0 ? "R1/R4" : (tcnt > 4 ? "R7" : "R6"));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    idle(3);
    chk(rx_dv == 0 && rx_stb == 0 && rx_er == 0, "R10 reset outputs", {rx_dv, rx_stb, rx_er}, 0);
    rst_n = 1'b1;
    carrier = 1'b1;
    idle(2);
    chk(rx_dv == 0 && rxd == 0, "R10 after reset", {rx_dv, rxd}, 0);

    // R9: noise outside a frame
    cap_n = 0;
    send(5'b01001); send(5'b01101); send(5'b10001); send(5'b00000);
    idle(2);
    chk(cap_n == 0 && rx_dv == 0, "R9 no output outside frame", cap_n, 0);

    // R3: false carrier
    cap_n = 0;
    send(5'b11000); send(5'b11111);
    chk(rx_dv == 0, "R3 dv low on false carrier", rx_dv, 0);
    send(5'b10001); send(enc(4'h3));
    idle(2);
    chk(cap_n == 0 && rx_dv == 0, "R3 no nibble after false carrier", cap_n, 0);

    // R1: all sixteen data values in order
    run_frame(16, -1, 0, 0, 4'h0, 1'b1);
    // R5: invalid group mid-frame
    run_frame(6, 3, 0, 0, 4'h0, 1'b0);
    // R6 boundaries: 1 and 4 leftover bits
    run_frame(3, -1, 1, 1, 4'b0000, 1'b0);
    run_frame(3, -1, 1, 4, 4'b1010, 1'b0);
    // R7 boundaries: 5, 7 and 0 leftover bits
    run_frame(2, -1, 1, 5, 4'b0110, 1'b0);
    run_frame(2, -1, 1, 7, 4'b0001, 1'b0);
    run_frame(4, -1, 1, 0, 4'b0000, 1'b0);

    // R8: carrier loss drops the held nibble
    cap_n = 0;
    send(5'b11000); send(5'b10001); send(enc(4'h9)); send(enc(4'h2));
    carrier = 1'b0;
    @(negedge clk);
    chk(rx_dv == 0 && rx_stb == 0, "R8 dv low after carrier loss", {rx_dv, rx_stb}, 0);
    carrier = 1'b1;
    idle(2);
    chk(cap_n == 3, "R8 nibble count", cap_n, 3);
    chk(cap_nib[2] == 4'h9, "R8 last nibble before loss", cap_nib[2], 9);

    // random frames
    for (int f = 0; f < 40; f++) begin
      int nd = $urandom_range(0, 20);
      int ep = ($urandom_range(0, 3) == 0 && nd > 0) ? int'($urandom_range(0, nd - 1)) : -1;
      run_frame(nd, ep, $urandom_range(0, 1), $urandom_range(0, 7), 4'($urandom_range(0, 15)), 1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule